// File: doc/BRIEF.md
# Pseudo-DMA Data Port

This block lets a CPU move data through a SCSI controller's byte buffer when the system has no DMA master. The controller arms a transfer by giving a start offset into the 32-byte buffer and a byte count. The block then raises a data-request line, and the CPU copies the data itself through a narrow window, one byte or one 16-bit halfword per access. Each access steps a buffer pointer forward and uses up part of the armed count. CPU writes also count down a 24-bit transfer counter, which the block presents as three byte registers.

When the armed count runs out, the request line drops. If the controller asked to be told about completion, the block emits one completion pulse. A completion can be of command kind or of status kind. A command completion issues a command only when at least one byte was moved. A status completion loads fixed status, interrupt and sequence codes and raises the interrupt line. A soft reset clears both lines and abandons the transfer. The controller loads and inspects buffer bytes through its own byte port.

Top module: `pdma_window`

## Requirements
- R1: When `arm_valid` is high, the next cycle has the pointer at `arm_start` and the remaining count at `arm_len`. `drq` is then high if `arm_len` is nonzero and low if it is zero.
- R2: `cpu_half`=1 selects a halfword access and `cpu_half`=0 a byte access. A halfword read returns buffer[ptr] on bits 15:8 and buffer[ptr+1] on bits 7:0. A byte read returns buffer[ptr] on bits 7:0 with bits 15:8 zero. A halfword write stores bits 15:8 at ptr and bits 7:0 at ptr+1. A byte write stores bits 7:0. `cpu_rdata` is zero in every cycle that has no accepted read.
- R3: An accepted access moves min(size, remaining) bytes. It advances the pointer by that amount, modulo 32, and lowers the remaining count by the same amount. `moved` reports the armed length minus the remaining count. When only one byte remains, a halfword read returns zero on bits 7:0 and a halfword write stores only bits 15:8.
- R4: `tc_load` loads the 24-bit transfer counter, which appears as `tc_hi`:`tc_mid`:`tc_lo`. An accepted write lowers it by the access size, 1 or 2, and stops at zero. Reads never change it, and a load wins over a write in the same cycle.
- R5: A CPU write while the transfer counter or the remaining count is zero changes no buffer byte, pointer, count or line.
- R6: A CPU read while the remaining count is zero returns zero and changes nothing.
- R7: The access that empties the remaining count drops `drq` on the next cycle. If a completion was requested (`arm_notify`), `done` pulses high for exactly one cycle at that same time and the request is consumed. Without `arm_notify` there is no pulse.
- R8: Arming with a zero length and `arm_notify` completes at once: `done` pulses on the next cycle with zero bytes moved. `cmd_issue` pulses together with `done` only for a command-kind completion (`arm_status`=0) that moved at least one byte.
- R9: A status-kind completion (`arm_status`=1) sets `stat_reg` to 0x13 (bit 4 terminal count, bits 2:0 = 3 status phase). It sets `intr_reg` to 0x18 (bit 4 bus service, bit 3 function complete) and `seq_reg` to 4 (command done), and sets `irq`. A command-kind completion leaves these and `irq` unchanged.
- R10: `soft_rst` lowers `drq` and `irq` on the next cycle. It also zeroes the remaining count and drops any pending completion. It takes priority over an arm or an access in the same cycle and leaves the transfer counter alone.
- R11: An arm in the same cycle as a CPU access wins: the access is discarded, with no buffer or counter change and zero read data.
- R12: `ctl_wr_en` writes `ctl_wdata` into buffer[`ctl_addr`], and `ctl_rdata` always shows buffer[`ctl_addr`]. A CPU write to the same byte in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous soft reset |
| arm_valid | input | 1 | Arm a transfer |
| arm_start | input | 5 | Buffer start offset |
| arm_len | input | 6 | Transfer length in bytes, 0 to 32 |
| arm_notify | input | 1 | Completion action requested |
| arm_status | input | 1 | Completion kind: 1 status, 0 command |
| ctl_wr_en | input | 1 | Controller buffer byte write |
| ctl_addr | input | 5 | Controller buffer address |
| ctl_wdata | input | 8 | Controller write byte |
| ctl_rdata | output | 8 | Buffer byte at ctl_addr |
| tc_load | input | 1 | Load transfer counter |
| tc_load_val | input | 24 | Counter load value |
| tc_lo | output | 8 | Counter bits 7:0 |
| tc_mid | output | 8 | Counter bits 15:8 |
| tc_hi | output | 8 | Counter bits 23:16 |
| cpu_req | input | 1 | CPU window access |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_half | input | 1 | 1 halfword, 0 byte |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data, same cycle |
| drq | output | 1 | Data request |
| irq | output | 1 | Interrupt |
| done | output | 1 | Completion pulse |
| cmd_issue | output | 1 | Command issue pulse |
| moved | output | 6 | Bytes moved in the current transfer |
| stat_reg | output | 8 | Status register |
| intr_reg | output | 8 | Interrupt register |
| seq_reg | output | 3 | Sequence-step register |

## Verification
Two pairs of functions can land in the same cycle: an arm and a CPU access, and a soft reset and the access that finishes a transfer. Directed steps put an arm on top of a read and on top of a write. Another directed step puts a soft reset on the final byte of a notified transfer. A pseudo-random phase then overlaps arms, accesses, counter loads, soft resets and controller byte writes freely. The bench's reference model applies the stated priority (soft reset, then arm, then access). Every output is compared against it each cycle, so a discarded access that still changes the buffer or the counter, or a completion that slips through a soft reset, shows up as a mismatch.

// File: rtl/pdma_window.sv
module pdma_window #(
  parameter int DEPTH = 32,
  parameter int TC_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     soft_rst,
  input  logic                     arm_valid,
  input  logic [$clog2(DEPTH)-1:0] arm_start,
  input  logic [$clog2(DEPTH):0]   arm_len,
  input  logic                     arm_notify,
  input  logic                     arm_status,
  input  logic                     ctl_wr_en,
  input  logic [$clog2(DEPTH)-1:0] ctl_addr,
  input  logic [7:0]               ctl_wdata,
  output logic [7:0]               ctl_rdata,
  input  logic                     tc_load,
  input  logic [TC_W-1:0]          tc_load_val,
  output logic [7:0]               tc_lo,
  output logic [7:0]               tc_mid,
  output logic [TC_W-17:0]         tc_hi,
  input  logic                     cpu_req,
  input  logic                     cpu_we,
  input  logic                     cpu_half,
  input  logic [15:0]              cpu_wdata,
  output logic [15:0]              cpu_rdata,
  output logic                     drq,
  output logic                     irq,
  output logic                     done,
  output logic                     cmd_issue,
  output logic [$clog2(DEPTH):0]   moved,
  output logic [7:0]               stat_reg,
  output logic [7:0]               intr_reg,
  output logic [2:0]               seq_reg
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = PW + 1;
  localparam logic [7:0] STAT_DONE = 8'h13;
  localparam logic [7:0] INTR_DONE = 8'h18;
  localparam logic [2:0] SEQ_DONE  = 3'd4;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] cur;
  logic [LW-1:0] len, rem;
  logic          pend, kind;
  logic [TC_W-1:0] tc;

  logic          acc, wr_ok, rd_ok, go, two, finish;
  logic [LW-1:0] nsz;
  logic [PW-1:0] nxt;
  logic [TC_W-1:0] dec;

  assign acc    = cpu_req && !arm_valid && !soft_rst && (rem != '0);
  assign wr_ok  = acc && cpu_we && (tc != '0);
  assign rd_ok  = acc && !cpu_we;
  assign go     = wr_ok || rd_ok;
  assign two    = cpu_half && (rem >= LW'(2));
  assign nsz    = two ? LW'(2) : LW'(1);
  assign nxt    = cur + PW'(1);
  assign finish = go && (rem == nsz);
  assign dec    = cpu_half ? TC_W'(2) : TC_W'(1);

  assign cpu_rdata = !rd_ok   ? 16'h0000 :
                     cpu_half ? {mem[cur], two ? mem[nxt] : 8'h00} :
                                {8'h00, mem[cur]};
  assign ctl_rdata = mem[ctl_addr];
  assign moved     = len - rem;
  assign tc_lo     = tc[7:0];
  assign tc_mid    = tc[15:8];
  assign tc_hi     = tc[TC_W-1:16];

  always_ff @(posedge clk) begin
    if (ctl_wr_en) mem[ctl_addr] <= ctl_wdata;
    if (wr_ok) begin
      mem[cur] <= cpu_half ? cpu_wdata[15:8] : cpu_wdata[7:0];
      if (two) mem[nxt] <= cpu_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tc <= '0;
    else if (tc_load)  tc <= tc_load_val;
    else if (wr_ok)    tc <= (tc > dec) ? tc - dec : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0; len <= '0; rem <= '0; pend <= 1'b0; kind <= 1'b0;
      drq <= 1'b0; irq <= 1'b0; done <= 1'b0; cmd_issue <= 1'b0;
      stat_reg <= '0; intr_reg <= '0; seq_reg <= '0;
    end else begin
      done      <= 1'b0;
      cmd_issue <= 1'b0;
      if (soft_rst) begin
        drq <= 1'b0; irq <= 1'b0; rem <= '0; pend <= 1'b0;
      end else if (arm_valid) begin
        cur  <= arm_start;
        len  <= arm_len;
        rem  <= arm_len;
        kind <= arm_status;
        if (arm_len != '0) begin
          drq  <= 1'b1;
          pend <= arm_notify;
        end else begin
          drq  <= 1'b0;
          pend <= 1'b0;
          if (arm_notify) begin
            done <= 1'b1;
            if (arm_status) begin
              stat_reg <= STAT_DONE; intr_reg <= INTR_DONE;
              seq_reg  <= SEQ_DONE;  irq      <= 1'b1;
            end
          end
        end
      end else if (go) begin
        cur <= cur + PW'(nsz);
        rem <= rem - nsz;
        if (finish) begin
          drq <= 1'b0;
          if (pend) begin
            pend <= 1'b0;
            done <= 1'b1;
            if (kind) begin
              stat_reg <= STAT_DONE; intr_reg <= INTR_DONE;
              seq_reg  <= SEQ_DONE;  irq      <= 1'b1;
            end else begin
              cmd_issue <= 1'b1;
            end
          end
        end
      end
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm_valid) |=> !done);
  a_r7_drq_low_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !drq);
  a_r8_no_empty_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue |-> (done && moved != '0));
  a_r9_irq_codes: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (stat_reg == STAT_DONE && intr_reg == INTR_DONE && seq_reg == SEQ_DONE));
  a_r10_soft_lines: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!drq && !irq));
  a_r4_read_keeps_tc: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && !tc_load) |=> $stable({tc_hi, tc_mid, tc_lo}));
endmodule

// File: tb/test_pdma_window.sv
module test_pdma_window;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b1;
  logic soft_rst = 0, arm_valid = 0, arm_notify = 0, arm_status = 0;
  logic [4:0] arm_start = 0, ctl_addr = 0;
  logic [5:0] arm_len = 0;
  logic ctl_wr_en = 0, tc_load = 0, cpu_req = 0, cpu_we = 0, cpu_half = 0;
  logic [7:0] ctl_wdata = 0;
  logic [23:0] tc_load_val = 0;
  logic [15:0] cpu_wdata = 0;
  logic [7:0] ctl_rdata, tc_lo, tc_mid, tc_hi, stat_reg, intr_reg;
  logic [15:0] cpu_rdata;
  logic drq, irq, done, cmd_issue;
  logic [5:0] moved;
  logic [2:0] seq_reg;

  pdma_window i_pdma_window (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .arm_valid(arm_valid), .arm_start(arm_start), .arm_len(arm_len),
    .arm_notify(arm_notify), .arm_status(arm_status),
    .ctl_wr_en(ctl_wr_en), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .tc_load(tc_load), .tc_load_val(tc_load_val), .tc_lo(tc_lo), .tc_mid(tc_mid), .tc_hi(tc_hi),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_half(cpu_half), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .drq(drq), .irq(irq), .done(done), .cmd_issue(cmd_issue), .moved(moved),
    .stat_reg(stat_reg), .intr_reg(intr_reg), .seq_reg(seq_reg));

  // reference model
  logic [7:0] mbuf [32];
  integer mcur, mlen, mrem, mtc;
  bit mpend, mkind, mdrq, mirq, mdone, mcmd;
  integer mstat, mintr, mseq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcur = 0; mlen = 0; mrem = 0; mtc = 0; mpend = 0; mkind = 0;
      mdrq = 0; mirq = 0; mdone = 0; mcmd = 0; mstat = 0; mintr = 0; mseq = 0;
    end else begin
      bit acc, wrok, rdok;
      integer nsz;
      mdone = 0; mcmd = 0;
      acc  = cpu_req && !arm_valid && !soft_rst && mrem != 0;
      wrok = acc && cpu_we && mtc != 0;
      rdok = acc && !cpu_we;
      nsz  = (cpu_half && mrem >= 2) ? 2 : 1;
      if (ctl_wr_en) mbuf[ctl_addr] = ctl_wdata;
      if (wrok) begin
        if (cpu_half) begin
          mbuf[mcur] = cpu_wdata[15:8];
          if (nsz == 2) mbuf[(mcur + 1) % 32] = cpu_wdata[7:0];
        end else mbuf[mcur] = cpu_wdata[7:0];
      end
      if (tc_load) mtc = tc_load_val;
      else if (wrok) mtc = (mtc > (cpu_half ? 2 : 1)) ? mtc - (cpu_half ? 2 : 1) : 0;
      if (soft_rst) begin
        mdrq = 0; mirq = 0; mrem = 0; mpend = 0;
      end else if (arm_valid) begin
        mcur = arm_start; mlen = arm_len; mrem = arm_len; mkind = arm_status;
        mdrq = (arm_len != 0);
        mpend = (arm_len != 0) && arm_notify;
        if (arm_len == 0 && arm_notify) begin
          mdone = 1;
          if (arm_status) begin mstat = 'h13; mintr = 'h18; mseq = 4; mirq = 1; end
        end
      end else if (wrok || rdok) begin
        mcur = (mcur + nsz) % 32;
        mrem = mrem - nsz;
        if (mrem == 0) begin
          mdrq = 0;
          if (mpend) begin
            mpend = 0; mdone = 1;
            if (mkind) begin mstat = 'h13; mintr = 'h18; mseq = 4; mirq = 1; end
            else mcmd = (mlen - mrem) != 0;
          end
        end
      end
    end
  end

  function automatic logic [15:0] exp_rdata();
    if (cpu_req && !cpu_we && !arm_valid && !soft_rst && mrem != 0)
      return cpu_half ? {mbuf[mcur], (mrem >= 2) ? mbuf[(mcur + 1) % 32] : 8'h00}
                      : {8'h00, mbuf[mcur]};
    return 16'h0000;
  endfunction

  integer nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  // per-cycle comparison, away from the active edge
  initial begin
    forever begin
      @(negedge clk); #5;
      chk("R1 drq", {31'b0, drq}, {31'b0, mdrq});
      chk("R2 rdata", {16'b0, cpu_rdata}, {16'b0, exp_rdata()});
      chk("R3 moved", {26'b0, moved}, 32'(mlen - mrem));
      chk("R4 tc", {8'b0, tc_hi, tc_mid, tc_lo}, 32'(mtc));
      chk("R12 ctl_rdata", {24'b0, ctl_rdata}, {24'b0, mbuf[ctl_addr]});
      chk("R7 done", {31'b0, done}, {31'b0, mdone});
      chk("R8 cmd_issue", {31'b0, cmd_issue}, {31'b0, mcmd});
      chk("R9 status regs", {5'b0, seq_reg, intr_reg, stat_reg}, {5'b0, 3'(mseq), 8'(mintr), 8'(mstat)});
      chk("R10 irq", {31'b0, irq}, {31'b0, mirq});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic idle();
    @(negedge clk);
    soft_rst = 0; arm_valid = 0; ctl_wr_en = 0; tc_load = 0; cpu_req = 0;
  endtask

  task automatic arm(input int s, input int l, input bit n, input bit st);
    idle();
    arm_valid = 1; arm_start = 5'(s); arm_len = 6'(l); arm_notify = n; arm_status = st;
  endtask

  task automatic acc(input bit we, input bit half, input logic [15:0] wd);
    idle();
    cpu_req = 1; cpu_we = we; cpu_half = half; cpu_wdata = wd;
  endtask

  task automatic load_tc(input int v);
    idle(); tc_load = 1; tc_load_val = 24'(v);
  endtask

  task automatic peek(input int a);
    idle(); ctl_addr = 5'(a);
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    #2 rst_n = 0;
    #30 rst_n = 1;
    // reset state
    @(negedge clk); #6;
    chk("R1 reset drq", {31'b0, drq}, 0);
    chk("R9 reset irq", {31'b0, irq}, 0);
    // R12: fill buffer through controller port
    for (int i = 0; i < 32; i++) begin
      idle(); ctl_wr_en = 1; ctl_addr = 5'(i); ctl_wdata = 8'(i * 7 + 3);
    end
    load_tc('h000101);
    // R1, R2, R3: command transfer wrapping past the buffer end
    arm(30, 5, 1, 0);
    acc(0, 1, 0);            // bytes 30,31
    acc(0, 0, 0);            // byte 0
    acc(0, 1, 0);            // bytes 1,2 -> completes, R7, R8
    idle(); #6;
    chk("R7 done seen late", {31'b0, done}, 1);
    chk("R8 cmd issued", {31'b0, cmd_issue}, 1);
    acc(0, 1, 0);            // R6: read after exhaustion returns zero
    #6 chk("R6 zero read", {16'b0, cpu_rdata}, 0);
    acc(1, 1, 16'hFFFF);     // R5: write with no remaining length ignored
    // R9: status transfer with writes, odd length
    arm(4, 3, 1, 1);
    acc(1, 1, 16'hA1B2);
    acc(1, 1, 16'hC3D4);     // one byte left: only C3 stored, R3
    idle(); #6;
    chk("R9 irq raised", {31'b0, irq}, 1);
    chk("R4 tc after writes", {8'b0, tc_hi, tc_mid, tc_lo}, 'h0000FD);
    peek(4); peek(5); peek(6); peek(7);
    // R5: write blocked by zero transfer counter
    load_tc(0);
    arm(8, 4, 1, 0);
    acc(1, 0, 16'h0055);
    idle(); #6 chk("R5 drq still high", {31'b0, drq}, 1);
    peek(8);
    // R11: arm collides with a write and with a read
    load_tc(10);
    idle(); arm_valid = 1; arm_start = 12; arm_len = 2; arm_notify = 1; arm_status = 0;
    cpu_req = 1; cpu_we = 1; cpu_half = 1; cpu_wdata = 16'h9999;
    idle(); arm_valid = 1; arm_start = 12; arm_len = 2; arm_notify = 1; arm_status = 0;
    cpu_req = 1; cpu_we = 0; cpu_half = 1;
    #6 chk("R11 read discarded", {16'b0, cpu_rdata}, 0);
    peek(12);
    // R10: soft reset on the final access
    idle(); soft_rst = 1; cpu_req = 1; cpu_we = 0; cpu_half = 1;
    idle(); #6;
    chk("R10 no done", {31'b0, done}, 0);
    chk("R10 irq low", {31'b0, irq}, 0);
    // R8: zero-length notified arm completes with no command
    arm(0, 0, 1, 0);
    idle(); #6;
    chk("R8 empty done", {31'b0, done}, 1);
    chk("R8 no cmd", {31'b0, cmd_issue}, 0);
    // R7: no notify -> no pulse
    arm(20, 1, 0, 0);
    acc(0, 0, 0);
    idle(); #6 chk("R7 no pulse", {31'b0, done}, 0);
    // pseudo-random overlap phase
    for (int k = 0; k < 600; k++) begin
      idle();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      arm_valid = (lfsr[3:0] == 0);
      arm_start = lfsr[8:4]; arm_len = {2'b0, lfsr[11:9], lfsr[0]};
      arm_notify = lfsr[12]; arm_status = lfsr[13];
      cpu_req = lfsr[14] | lfsr[1]; cpu_we = lfsr[15]; cpu_half = lfsr[2];
      cpu_wdata = {lfsr[7:0], lfsr[15:8]};
      tc_load = (lfsr[6:2] == 5'd7); tc_load_val = {16'b0, lfsr[7:0]};
      soft_rst = (lfsr[10:5] == 6'd9);
      ctl_wr_en = lfsr[9] & lfsr[11]; ctl_addr = lfsr[12:8]; ctl_wdata = lfsr[7:0];
    end
    idle(); idle();
    finish_run();
  end
endmodule